// File: doc/BRIEF.md
# Preemptive DMA Channel Priority Tracker

This block records which of six DMA channels currently owns the transfer engine. Each channel raises a one-cycle start strobe when it wants service and a one-cycle done strobe when its transfer ends. Starts that cannot be granted at once are held as pending requests. When the active channel finishes, a fixed-order selector grants the lowest-numbered pending channel.

A mode input turns channel 1 into an urgent channel. In that mode a channel 1 request takes over at once, even if another channel is running. The code of the channel it displaced is parked in a shadow field. When channel 1 signals done, the parked code becomes active again and that channel carries on to its own done strobe.

Both codes appear in a read-only 16-bit status word for software to poll. The status word is plain control and status, not a data stream, so it has no handshake.

Top module: `prio_track`

## Requirements
- R1: A channel code is 3 bits wide. Value 0 means idle and value n (1 to 6) means channel n. Neither field ever holds 7.
- R2: `status_o` carries the active code in bits [2:0] and the shadow code in bits [6:4]. Bit 3 and bits [15:7] are always zero.
- R3: While `rst_n` is low, both codes are zero. Reset also clears every pending request.
- R4: With `hp_mode_i` high, a channel 1 request while channel 1 is not active does two things on that clock edge. The shadow takes the old active code (0 if idle) and the active code becomes 1.
- R5: With `hp_mode_i` high, channel 1's done strobe loads the active code from the shadow. The shadow keeps its value.
- R6: A start strobe for the channel that is already active is absorbed. It triggers no preemption, leaves the shadow unchanged and is not queued.
- R7: With `hp_mode_i` low, channel 1 never preempts. Its request waits like any other. The shadow is neither written on grant nor read back on channel 1's done.
- R8: Start bit k-1 requests channel k. When the active code is 0, or the active channel's done arrives without a restore, the lowest-numbered channel among pending and same-cycle starts is granted on that edge. If none is waiting, the code becomes 0.
- R9: A done strobe for a channel that is not active has no effect.
- R10: If a preempting channel 1 request and the active channel's done arrive in the same cycle, the preemption wins and that done is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_mode_i | input | 1 | Channel 1 urgent/preemptive mode enable |
| start_i | input | 6 | Per-channel start strobes, bit k-1 for channel k |
| done_i | input | 6 | Per-channel done strobes, bit k-1 for channel k |
| act_o | output | 3 | Active channel code |
| shd_o | output | 3 | Shadow (interrupted channel) code |
| status_o | output | 16 | Read-only packed status word |

## Verification
Two conditions are hard to reach from the ports.

The first is proving that mode-off operation neither writes nor restores the shadow. That only shows up if the shadow already holds a nonzero code. The stimulus therefore first preempts channel 5 in urgent mode, then drops the mode and runs channel 1 to completion. It checks that the active code returns to 0 rather than 5.

The second is the collision of a preemption with the running channel's own done. It is created by driving both strobes in one cycle. The later restore of that channel then shows that its done was indeed discarded.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int NCH = 6;
  localparam int CW  = $clog2(NCH + 1);
  localparam int SW  = 16;
  localparam int SHD_LSB = 4;
  typedef logic [CW-1:0]  code_t;
  typedef logic [NCH-1:0] mask_t;
endpackage

// File: rtl/prio_pending.sv
module prio_pending #(
  parameter int NCH = prio_pkg::NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] pend_o
);
  logic [NCH-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= set_i & ~clr_i;
  end

  assign pend_o = pend_q;

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_i)) == '0)); // R8
endmodule

// File: rtl/prio_select.sv
module prio_select #(
  parameter int NCH = prio_pkg::NCH,
  localparam int CW = $clog2(NCH + 1)
) (
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] gnt_o,
  output logic [CW-1:0]  code_o
);
  logic [NCH:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NCH; g++) begin : g_chain
    assign gnt_o[g]    = req_i[g] & ~seen[g];
    assign seen[g + 1] = seen[g] | req_i[g];
  end

  always_comb begin
    code_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (gnt_o[i]) code_o = CW'(i + 1);
    end
  end

  always_comb begin
    if (req_i != '0) AST_ONE_GRANT: assert ($onehot0(gnt_o) && gnt_o != '0); // R8
  end
endmodule

// File: rtl/prio_core.sv
module prio_core #(
  parameter int NCH = prio_pkg::NCH,
  localparam int CW = $clog2(NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hp_mode_i,
  input  logic [NCH-1:0] start_i,
  input  logic [NCH-1:0] done_i,
  input  logic [NCH-1:0] pend_i,
  input  logic [NCH-1:0] sel_gnt_i,
  input  logic [CW-1:0]  sel_code_i,
  output logic [NCH-1:0] req_o,
  output logic [NCH-1:0] clr_o,
  output logic [CW-1:0]  act_o,
  output logic [CW-1:0]  shd_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0]  act_q, shd_q, act_d, shd_d;
  logic [NCH-1:0] act_oh;
  logic           preempt, act_done, restore;

  for (genvar g = 0; g < NCH; g++) begin : g_oh
    assign act_oh[g] = (act_q == CW'(g + 1));
  end

  assign req_o    = (pend_i | start_i) & ~act_oh;
  assign preempt  = hp_mode_i & req_o[0];
  assign act_done = |(done_i & act_oh);
  assign restore  = hp_mode_i & act_done & (act_q == ONE);

  always_comb begin
    act_d = act_q;
    shd_d = shd_q;
    clr_o = '0;
    if (preempt) begin
      shd_d    = act_q;
      act_d    = ONE;
      clr_o[0] = 1'b1;
    end else if (restore) begin
      act_d = shd_q;
    end else if (act_done || act_q == '0) begin
      act_d = sel_code_i;
      clr_o = sel_gnt_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      shd_q <= '0;
    end else begin
      act_q <= act_d;
      shd_q <= shd_d;
    end
  end

  assign act_o = act_q;
  assign shd_o = shd_q;

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q <= CW'(NCH)) && (shd_q <= CW'(NCH))); // R1
  AST_PREEMPT_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_mode_i && start_i[0] && act_q != ONE) |=> (act_q == ONE && shd_q == $past(act_q))); // R4
  AST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_mode_i && act_q == ONE && done_i[0]) |=> (act_q == $past(shd_q) && $stable(shd_q))); // R5
  AST_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_mode_i && act_q == ONE && !done_i[0]) |=> (act_q == ONE && $stable(shd_q))); // R6
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hp_mode_i && act_q != '0 && (done_i & act_oh) == '0) |=> $stable(act_q)); // R7
  AST_OFF_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_mode_i |=> $stable(shd_q)); // R7
endmodule

// File: rtl/prio_track.sv
module prio_track #(
  parameter int NCH = prio_pkg::NCH,
  parameter int SW  = prio_pkg::SW,
  parameter int SHD_LSB = prio_pkg::SHD_LSB,
  localparam int CW = $clog2(NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hp_mode_i,
  input  logic [NCH-1:0] start_i,
  input  logic [NCH-1:0] done_i,
  output logic [CW-1:0]  act_o,
  output logic [CW-1:0]  shd_o,
  output logic [SW-1:0]  status_o
);
  logic [NCH-1:0] pend, req, clr, sel_gnt;
  logic [CW-1:0]  sel_code;

  prio_pending #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(req), .clr_i(clr), .pend_o(pend)
  );

  prio_select #(.NCH(NCH)) u_sel (
    .req_i(req), .gnt_o(sel_gnt), .code_o(sel_code)
  );

  prio_core #(.NCH(NCH)) u_core (
    .clk(clk), .rst_n(rst_n), .hp_mode_i(hp_mode_i),
    .start_i(start_i), .done_i(done_i), .pend_i(pend),
    .sel_gnt_i(sel_gnt), .sel_code_i(sel_code),
    .req_o(req), .clr_o(clr), .act_o(act_o), .shd_o(shd_o)
  );

  always_comb begin
    status_o = '0;
    status_o[CW-1:0] = act_o;
    status_o[SHD_LSB +: CW] = shd_o;
  end

  always_comb begin
    AST_STATUS_PAD: assert (status_o[SW-1:SHD_LSB+CW] == '0 && status_o[SHD_LSB-1:CW] == '0); // R2
  end
endmodule

// File: tb/tb_prio_track.sv
module tb_prio_track;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hp = 1'b0;
  logic [5:0] st = '0;
  logic [5:0] dn = '0;
  logic [2:0] act, shd;
  logic [15:0] status;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  prio_track dut (
    .clk(clk), .rst_n(rst_n), .hp_mode_i(hp), .start_i(st), .done_i(dn),
    .act_o(act), .shd_o(shd), .status_o(status)
  );

  // {hp, start[5:0], done[5:0], expected act, expected shadow}
  localparam int NV = 21;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 6'b000100, 6'b000000, 3'd3, 3'd0},  // R8 idle grant
    {1'b1, 6'b000001, 6'b000100, 3'd1, 3'd3},  // R10 preempt beats done
    {1'b1, 6'b000001, 6'b000000, 3'd1, 3'd3},  // R6 self start absorbed
    {1'b1, 6'b000000, 6'b000001, 3'd3, 3'd3},  // R5 restore
    {1'b1, 6'b000000, 6'b000100, 3'd0, 3'd3},  // R8 finish, none waiting
    {1'b1, 6'b010010, 6'b000000, 3'd2, 3'd3},  // R8 lowest first
    {1'b1, 6'b000000, 6'b010000, 3'd2, 3'd3},  // R9 foreign done
    {1'b1, 6'b000000, 6'b000010, 3'd5, 3'd3},  // R8 next pending
    {1'b1, 6'b000001, 6'b000000, 3'd1, 3'd5},  // R4 preempt
    {1'b1, 6'b000000, 6'b000001, 3'd5, 3'd5},  // R5 restore
    {1'b1, 6'b000000, 6'b010000, 3'd0, 3'd5},  // R8
    {1'b0, 6'b000001, 6'b000000, 3'd1, 3'd5},  // R7 no shadow write
    {1'b0, 6'b000000, 6'b000001, 3'd0, 3'd5},  // R7 no restore
    {1'b1, 6'b000001, 6'b000000, 3'd1, 3'd0},  // R4 preempt from idle
    {1'b1, 6'b000000, 6'b000001, 3'd0, 3'd0},  // R5 restore to idle
    {1'b0, 6'b001000, 6'b000000, 3'd4, 3'd0},  // R8
    {1'b0, 6'b000001, 6'b000000, 3'd4, 3'd0},  // R7 no preempt
    {1'b0, 6'b000000, 6'b001000, 3'd1, 3'd0},  // R7 queued ch1 granted
    {1'b0, 6'b000000, 6'b000001, 3'd0, 3'd0},  // R8
    {1'b0, 6'b100000, 6'b000000, 3'd6, 3'd0},  // R1 top code
    {1'b0, 6'b000000, 6'b100000, 3'd0, 3'd0}   // R1
  };

  task automatic check(input string req, input logic [2:0] ea, input logic [2:0] es);
    logic [15:0] ew;
    ew = {9'b0, es, 1'b0, ea};
    n_chk++;
    if (act !== ea || shd !== es || status !== ew) begin
      n_bad++;
      $display("FAIL %s: act=%0d shd=%0d status=%h expected act=%0d shd=%0d status=%h (R2)",
               req, act, shd, status, ea, es, ew);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset", 3'd0, 3'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 after release", 3'd0, 3'd0);

    for (int i = 0; i < NV; i++) begin
      hp = VEC[i][18];
      st = VEC[i][17:12];
      dn = VEC[i][11:6];
      @(posedge clk);
      #1;
      check($sformatf("R1/R4-R10 vector %0d", i), VEC[i][5:3], VEC[i][2:0]);
      @(negedge clk);
      st = '0;
      dn = '0;
    end

    // R3: mid-run reset drops active code and pending queue
    hp = 1'b0;
    st = 6'b000010;
    @(negedge clk);
    st = 6'b000100;
    @(negedge clk);
    st = '0;
    check("R8 pre-reset", 3'd2, 3'd0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R3 mid reset", 3'd0, 3'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 pending cleared", 3'd0, 3'd0);

    // R9: done for idle block does nothing
    dn = 6'b111111;
    @(negedge clk);
    dn = '0;
    check("R9 done while idle", 3'd0, 3'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule